// File: doc/BRIEF.md
# Byte-Serial CRC-16/CRC-32 Engine

This block folds a stream of bytes into a running checksum, one byte per clock. An 8-bit control register sets three things. It picks the width: CRC-16 or CRC-32. It picks which of four byte sources feeds the engine: a register-write path, a flash-read stream, or one of two DMA channels. It also accepts a preset command that loads the running register with all zeros or all ones. The result can be read at any time on `checksum`.

A run starts with the first byte accepted from the selected source, and `busy` rises with it. While `busy` is high, the width bit and the source field are locked. Writes to them are dropped. The run ends in one of two ways. For flash or DMA, the selected source raises its done strobe. For any source, a preset command ends it. Bytes and done strobes from sources that are not selected have no effect.

The control logic is a three-state machine:
- `ST_IDLE` is waiting.
- `ST_RUN` is busy.
- `ST_PRESET` is the one-cycle wait before a preset lands.

Its transitions are:
- IDLE→RUN on an accepted byte that has no done strobe with it.
- RUN→IDLE on done from the selected source.
- any→PRESET on a preset write.
- PRESET→IDLE unconditionally.

Top module: `crc_engine`

## Requirements
- R1: After reset, `ctrl_rdata` is 0x00, `busy` is 0, `checksum` is 0 and the width is CRC-16.
- R2: `ctrl_rdata` reads as {2'b00, width bit, 1'b0, source[3:0]}. The preset field in bits 7:6 and reserved bit 4 always read as zero.
- R3: A write with bit 7 set is a preset. Bit 6 picks the fill: 0 gives all zeros, 1 gives all ones. `busy` is low after the first rising edge following the write. The running register takes the fill on the second rising edge, and bytes offered in between are dropped.
- R4: A write with bits 7:6 equal to 00 or 01 leaves the running register untouched.
- R5: Bit 5 selects CRC-32 when 1 and CRC-16 when 0. It is written only while `busy` is low; a write while busy leaves it unchanged.
- R6: CRC-16 uses polynomial 0x1021, MSB first, on the low 16 bits of the running register. `checksum` is {16'h0, reg[15:0]}. After a ones preset, the ASCII bytes "123456789" give 0x29B1.
- R7: CRC-32 uses the reflected polynomial 0xEDB88320, LSB first. `checksum` is the bitwise complement of the running register. After a ones preset, "123456789" gives 0xCBF43926, and straight after the preset `checksum` reads 0.
- R8: The source codes are 0 = off, 1 = register path (`io_wr`/`io_data`), 2 = flash, 4 = DMA channel 0 and 5 = DMA channel 1. The source field is written only while `busy` is low.
- R9: `busy` rises after the first accepted byte from the selected source. Bytes and done strobes from any other source leave `checksum` and `busy` unchanged.
- R10: A done strobe from the selected flash or DMA source clears `busy` at the next edge. A byte offered in the same cycle is still folded in.
- R11: With source code 0, 3 or 6–15, no byte is accepted, `busy` stays 0 and `checksum` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| io_wr | input | 1 | Register-path byte write strobe |
| io_data | input | 8 | Register-path byte |
| flash_vld | input | 1 | Flash byte valid |
| flash_byte | input | 8 | Flash byte |
| flash_done | input | 1 | Flash stream complete |
| dma0_vld | input | 1 | DMA channel 0 byte valid |
| dma0_byte | input | 8 | DMA channel 0 byte |
| dma0_done | input | 1 | DMA channel 0 complete |
| dma1_vld | input | 1 | DMA channel 1 byte valid |
| dma1_byte | input | 8 | DMA channel 1 byte |
| dma1_done | input | 1 | DMA channel 1 complete |
| busy | output | 1 | A run is in progress |
| checksum | output | 32 | Current checksum |

## Verification
The hardest situation to reach is a run where the selected source streams bytes while the other ports also carry traffic. Unselected channels offer their own bytes and raise done strobes, and control writes try to flip the width or the source in the middle of the run. Only correct source gating and locking leave the checksum on the reference value.

The stimulus reaches this state with randomised runs. Each cycle that carries a selected byte also drives a random unselected source and a random foreign done strobe. Directed steps cover the rest:
- a locked write during a run
- a preset issued mid-run
- a final byte that shares its cycle with the done strobe.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int BYTE_W = 8;
    localparam int SRC_W  = 4;
    localparam int C16_W  = 16;
    localparam int C32_W  = 32;

    localparam logic [SRC_W-1:0] SRC_OFF   = 4'd0;
    localparam logic [SRC_W-1:0] SRC_IO    = 4'd1;
    localparam logic [SRC_W-1:0] SRC_FLASH = 4'd2;
    localparam logic [SRC_W-1:0] SRC_DMA0  = 4'd4;
    localparam logic [SRC_W-1:0] SRC_DMA1  = 4'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_PRESET = 2'd2
    } eng_state_t;

    // One byte folded MSB first into a 16-bit register.
    function automatic logic [C16_W-1:0] crc16_step(
        input logic [C16_W-1:0]  cur,
        input logic [BYTE_W-1:0] din,
        input logic [C16_W-1:0]  poly
    );
        logic [C16_W-1:0] acc;
        acc = cur ^ {din, {(C16_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
            acc = acc[C16_W-1] ? ((acc << 1) ^ poly) : (acc << 1);
        end
        return acc;
    endfunction

    // One byte folded LSB first into a reflected 32-bit register.
    function automatic logic [C32_W-1:0] crc32_step(
        input logic [C32_W-1:0]  cur,
        input logic [BYTE_W-1:0] din,
        input logic [C32_W-1:0]  poly
    );
        logic [C32_W-1:0] acc;
        acc = cur ^ {{(C32_W-BYTE_W){1'b0}}, din};
        for (int i = 0; i < BYTE_W; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ poly) : (acc >> 1);
        end
        return acc;
    endfunction

endpackage

// File: rtl/crc_src_mux.sv
module crc_src_mux
    import crc_eng_pkg::*;
(
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_data,
    input  logic              flash_vld,
    input  logic [BYTE_W-1:0] flash_byte,
    input  logic              flash_done,
    input  logic              dma0_vld,
    input  logic [BYTE_W-1:0] dma0_byte,
    input  logic              dma0_done,
    input  logic              dma1_vld,
    input  logic [BYTE_W-1:0] dma1_byte,
    input  logic              dma1_done,
    output logic              sel_vld,
    output logic [BYTE_W-1:0] sel_byte,
    output logic              sel_done
);

    always_comb begin
        sel_vld  = 1'b0;
        sel_byte = '0;
        sel_done = 1'b0;
        unique case (src_sel)
            SRC_IO: begin
                sel_vld  = io_wr;
                sel_byte = io_data;
            end
            SRC_FLASH: begin
                sel_vld  = flash_vld;
                sel_byte = flash_byte;
                sel_done = flash_done;
            end
            SRC_DMA0: begin
                sel_vld  = dma0_vld;
                sel_byte = dma0_byte;
                sel_done = dma0_done;
            end
            SRC_DMA1: begin
                sel_vld  = dma1_vld;
                sel_byte = dma1_byte;
                sel_done = dma1_done;
            end
            default: begin
                sel_vld  = 1'b0;
                sel_byte = '0;
                sel_done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/crc_ctrl_fsm.sv
module crc_ctrl_fsm
    import crc_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              sel_vld,
    input  logic              sel_done,
    output logic              mode32,
    output logic [SRC_W-1:0]  src_sel,
    output logic              busy,
    output logic              preset_en,
    output logic              preset_fill,
    output logic              byte_en
);

    localparam int PRE_BIT  = BYTE_W - 1;
    localparam int FILL_BIT = BYTE_W - 2;
    localparam int MODE_BIT = BYTE_W - 3;
    localparam int RSVD_BIT = BYTE_W - 4;

    eng_state_t state_q, state_nx;
    logic       mode_q;
    logic [SRC_W-1:0] src_q;
    logic       fill_q;
    logic       preset_cmd;
    logic       unused_rsvd;

    assign preset_cmd  = reg_wr && reg_wdata[PRE_BIT];
    assign unused_rsvd = reg_wdata[RSVD_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        if (preset_cmd) begin
            state_nx = ST_PRESET;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (sel_vld && !sel_done) state_nx = ST_RUN;
                ST_RUN:    if (sel_done)             state_nx = ST_IDLE;
                ST_PRESET:                           state_nx = ST_IDLE;
                default:                             state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        preset_en = 1'b0;
        byte_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                byte_en = sel_vld;
            end
            ST_RUN: begin
                busy    = 1'b1;
                byte_en = sel_vld;
            end
            ST_PRESET: begin
                preset_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // control fields, locked while a run is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            src_q  <= SRC_OFF;
            fill_q <= 1'b0;
        end else if (reg_wr) begin
            if (preset_cmd) begin
                fill_q <= reg_wdata[FILL_BIT];
            end
            if (!busy) begin
                mode_q <= reg_wdata[MODE_BIT];
                src_q  <= reg_wdata[SRC_W-1:0];
            end
        end
    end

    assign mode32      = mode_q;
    assign src_sel     = src_q;
    assign preset_fill = fill_q;

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
    import crc_eng_pkg::*;
#(
    parameter logic [C16_W-1:0] POLY16 = 16'h1021,
    parameter logic [C32_W-1:0] POLY32 = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_en,
    input  logic              preset_fill,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              mode32,
    output logic [C32_W-1:0]  checksum
);

    localparam int HI_W = C32_W - C16_W;

    logic [C32_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (preset_en) begin
            run_q <= {C32_W{preset_fill}};
        end else if (byte_en) begin
            if (mode32) begin
                run_q <= crc32_step(run_q, byte_in, POLY32);
            end else begin
                run_q[C16_W-1:0] <= crc16_step(run_q[C16_W-1:0], byte_in, POLY16);
            end
        end
    end

    assign checksum = mode32 ? ~run_q : {{HI_W{1'b0}}, run_q[C16_W-1:0]};

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
#(
    parameter logic [15:0] POLY16 = 16'h1021,
    parameter logic [31:0] POLY32 = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  ctrl_rdata,
    input  logic        io_wr,
    input  logic [7:0]  io_data,
    input  logic        flash_vld,
    input  logic [7:0]  flash_byte,
    input  logic        flash_done,
    input  logic        dma0_vld,
    input  logic [7:0]  dma0_byte,
    input  logic        dma0_done,
    input  logic        dma1_vld,
    input  logic [7:0]  dma1_byte,
    input  logic        dma1_done,
    output logic        busy,
    output logic [31:0] checksum
);

    logic              sel_vld;
    logic [BYTE_W-1:0] sel_byte;
    logic              sel_done;
    logic              mode32;
    logic [SRC_W-1:0]  src_sel;
    logic              preset_en;
    logic              preset_fill;
    logic              byte_en;

    crc_src_mux u_mux (
        .src_sel    (src_sel),
        .io_wr      (io_wr),
        .io_data    (io_data),
        .flash_vld  (flash_vld),
        .flash_byte (flash_byte),
        .flash_done (flash_done),
        .dma0_vld   (dma0_vld),
        .dma0_byte  (dma0_byte),
        .dma0_done  (dma0_done),
        .dma1_vld   (dma1_vld),
        .dma1_byte  (dma1_byte),
        .dma1_done  (dma1_done),
        .sel_vld    (sel_vld),
        .sel_byte   (sel_byte),
        .sel_done   (sel_done)
    );

    crc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .sel_vld     (sel_vld),
        .sel_done    (sel_done),
        .mode32      (mode32),
        .src_sel     (src_sel),
        .busy        (busy),
        .preset_en   (preset_en),
        .preset_fill (preset_fill),
        .byte_en     (byte_en)
    );

    crc_datapath #(
        .POLY16 (POLY16),
        .POLY32 (POLY32)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .preset_en   (preset_en),
        .preset_fill (preset_fill),
        .byte_en     (byte_en),
        .byte_in     (sel_byte),
        .mode32      (mode32),
        .checksum    (checksum)
    );

    assign ctrl_rdata = {2'b00, mode32, 1'b0, src_sel};

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  ctrl_rdata,
    input logic        flash_done,
    input logic        dma0_done,
    input logic        dma1_done,
    input logic        busy,
    input logic [31:0] checksum
);

    logic unused_chk;
    assign unused_chk = ^reg_wdata[6:0];

    logic sel_done_seen;
    assign sel_done_seen = (ctrl_rdata[3:0] == 4'd2 && flash_done) ||
                           (ctrl_rdata[3:0] == 4'd4 && dma0_done)  ||
                           (ctrl_rdata[3:0] == 4'd5 && dma1_done);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7:6] == 2'b00) && (ctrl_rdata[4] == 1'b0));

    p_preset_drops_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7]) |=> !busy);

    p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_rdata[5]));

    p_src_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_rdata[3:0]));

    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_done_seen) |=> !busy);

    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[3:0] == 4'd0 && !reg_wr && !$past(reg_wr)) |=> ($stable(checksum) && !busy));

endmodule

bind crc_engine crc_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .ctrl_rdata (ctrl_rdata),
    .flash_done (flash_done),
    .dma0_done  (dma0_done),
    .dma1_done  (dma1_done),
    .busy       (busy),
    .checksum   (checksum)
);

// File: tb/tb_crc_engine.sv
`timescale 1ns/1ps
module tb_crc_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = '0;
    logic        flash_vld = 1'b0;
    logic [7:0]  flash_byte = '0;
    logic        flash_done = 1'b0;
    logic        dma0_vld = 1'b0;
    logic [7:0]  dma0_byte = '0;
    logic        dma0_done = 1'b0;
    logic        dma1_vld = 1'b0;
    logic [7:0]  dma1_byte = '0;
    logic        dma1_done = 1'b0;
    logic        busy;
    logic [31:0] checksum;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crc_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .io_wr(io_wr), .io_data(io_data),
        .flash_vld(flash_vld), .flash_byte(flash_byte), .flash_done(flash_done),
        .dma0_vld(dma0_vld), .dma0_byte(dma0_byte), .dma0_done(dma0_done),
        .dma1_vld(dma1_vld), .dma1_byte(dma1_byte), .dma1_done(dma1_done),
        .busy(busy), .checksum(checksum)
    );

    // bit-serial references, independent of the unrolled hardware form
    function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[15] ^ b[7-i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref32(input logic [31:0] c, input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[0] ^ b[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_src(input logic [3:0] s, input logic [7:0] b);
        case (s)
            4'd1: begin io_wr = 1'b1; io_data = b; end
            4'd2: begin flash_vld = 1'b1; flash_byte = b; end
            4'd4: begin dma0_vld = 1'b1; dma0_byte = b; end
            4'd5: begin dma1_vld = 1'b1; dma1_byte = b; end
            default: ;
        endcase
    endtask

    task automatic set_done(input logic [3:0] s);
        case (s)
            4'd2: flash_done = 1'b1;
            4'd4: dma0_done  = 1'b1;
            4'd5: dma1_done  = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clear_all();
        io_wr = 1'b0; flash_vld = 1'b0; dma0_vld = 1'b0; dma1_vld = 1'b0;
        flash_done = 1'b0; dma0_done = 1'b0; dma1_done = 1'b0;
    endtask

    // one clock: selected byte, junk byte on another port, done strobe (0 = none)
    task automatic cyc(input logic [3:0] bs, input logic [7:0] b,
                       input logic [3:0] js, input logic [7:0] jb,
                       input logic [3:0] ds);
        set_src(js, jb);
        set_src(bs, b);
        set_done(ds);
        @(negedge clk);
        clear_all();
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [15:0] e16;
        logic [31:0] e32;
        logic [31:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl", {24'h0, ctrl_rdata}, 32'h00);
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 checksum", checksum, 32'h0);

        // R2/R3 preset ones, CRC-16, register path
        wr(8'hC1);
        check("R2 readback", {24'h0, ctrl_rdata}, 32'h01);
        check("R3 not yet preset", checksum, 32'h0);
        cyc(0, 0, 0, 0, 0);
        check("R3 ones preset", checksum, 32'h0000FFFF);

        // R6 check string, R9 busy rises
        e16 = 16'hFFFF;
        for (int i = 0; i < 9; i++) begin
            cyc(4'd1, 8'h31 + 8'(i), 0, 0, 0);
            e16 = ref16(e16, 8'h31 + 8'(i));
            if (i == 0) check("R9 busy after first byte", {31'h0, busy}, 32'h1);
        end
        check("R6 check value", checksum, 32'h000029B1);
        check("R6 ref model", checksum, {16'h0, e16});

        // R5/R8 locked fields
        wr(8'h25);
        check("R5 R8 write while busy dropped", {24'h0, ctrl_rdata}, 32'h01);
        check("R5 busy kept", {31'h0, busy}, 32'h1);

        // R3 zero preset mid-run
        wr(8'h80);
        check("R3 busy drops first edge", {31'h0, busy}, 32'h0);
        cyc(4'd1, 8'hAA, 0, 0, 0);
        check("R3 zero preset, byte in gap dropped", checksum, 32'h0);

        // R4 reserved / no-op preset codes
        wr(8'h41);
        cyc(0, 0, 0, 0, 0);
        check("R4 code 01 no effect", checksum, 32'h0);
        wr(8'h01);
        cyc(0, 0, 0, 0, 0);
        check("R4 code 00 no effect", checksum, 32'h0);

        // R7 CRC-32 on flash with foreign traffic
        wr(8'hE2);
        cyc(0, 0, 0, 0, 0);
        check("R7 ctrl", {24'h0, ctrl_rdata}, 32'h22);
        check("R7 preset reads zero", checksum, 32'h0);
        e32 = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) begin
            cyc(4'd2, 8'h31 + 8'(i), 4'd4, 8'h5A, 4'd5);
            e32 = ref32(e32, 8'h31 + 8'(i));
        end
        check("R7 check value", checksum, 32'hCBF43926);
        check("R9 foreign done ignored", {31'h0, busy}, 32'h1);
        held = checksum;
        cyc(0, 0, 4'd5, 8'h77, 4'd4);
        check("R9 foreign byte ignored", checksum, held);

        // R10 byte with done
        cyc(4'd2, 8'h41, 0, 0, 4'd2);
        e32 = ref32(e32, 8'h41);
        check("R10 busy clears", {31'h0, busy}, 32'h0);
        check("R10 last byte folded", checksum, ~e32);

        // R5 writable when idle
        wr(8'h02);
        check("R5 idle write", {24'h0, ctrl_rdata}, 32'h02);

        // R11 disabled and reserved sources
        wr(8'h00);
        held = checksum;
        cyc(4'd1, 8'h11, 4'd2, 8'h22, 0);
        cyc(4'd4, 8'h33, 4'd5, 8'h44, 0);
        check("R11 off checksum", checksum, held);
        check("R11 off busy", {31'h0, busy}, 32'h0);
        wr(8'h03);
        check("R11 reserved src readback", {24'h0, ctrl_rdata}, 32'h03);
        cyc(4'd2, 8'h55, 4'd1, 8'h66, 0);
        check("R11 reserved checksum", checksum, held);
        check("R11 reserved busy", {31'h0, busy}, 32'h0);

        // random runs: R6 R7 R8 R9 R10
        for (int r = 0; r < 40; r++) begin
            logic [3:0] s;
            logic [3:0] js;
            logic [3:0] ds;
            logic       m;
            logic       f;
            int         len;
            logic [31:0] c;
            logic [7:0]  b;
            case ($urandom_range(0, 2))
                0: s = 4'd2;
                1: s = 4'd4;
                default: s = 4'd5;
            endcase
            m   = 1'($urandom_range(0, 1));
            f   = 1'($urandom_range(0, 1));
            len = $urandom_range(2, 12);
            wr({1'b1, f, m, 1'b0, s});
            cyc(0, 0, 0, 0, 0);
            check("R8 random source readback", {24'h0, ctrl_rdata}, {24'h0, 2'b00, m, 1'b0, s});
            c = {32{f}};
            for (int k = 0; k < len; k++) begin
                b = 8'($urandom);
                case ($urandom_range(0, 3))
                    0: js = 4'd1;
                    1: js = 4'd2;
                    2: js = 4'd4;
                    default: js = 4'd5;
                endcase
                if (js == s) js = 4'd0;
                case ($urandom_range(0, 3))
                    0: ds = 4'd2;
                    1: ds = 4'd4;
                    2: ds = 4'd5;
                    default: ds = 4'd0;
                endcase
                if (ds == s) ds = 4'd0;
                if (k == len - 1) ds = s;
                cyc(s, b, js, 8'($urandom), ds);
                if (m) c = ref32(c, b);
                else   c[15:0] = ref16(c[15:0], b);
                if (k == 0) check("R9 random busy", {31'h0, busy}, 32'h1);
                if (k == 1 && len > 2) begin
                    wr({2'b00, ~m, 1'b0, 4'd1});
                    check("R8 random lock", {24'h0, ctrl_rdata}, {24'h0, 2'b00, m, 1'b0, s});
                end
            end
            check("R10 random busy clear", {31'h0, busy}, 32'h0);
            if (m) check("R7 random crc32", checksum, ~c);
            else   check("R6 random crc16", checksum, {16'h0, c[15:0]});
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule